// File: doc/BRIEF.md
# Tag Array Stimulus Sequencer

This block produces a fixed, repeatable stream of test vectors for an eight-way set-associative tag array. After `start`, it walks a set sequence of phases. It first seeds a few cells. It then runs an address march of stores in ascending set order, followed by loads of the same sets in descending order. Next comes a data march of walking-one and then walking-zero patterns. A pseudo-random phase follows, issuing loads and stores whose address, way and data come from a 16-bit maximal-length LFSR. The last phase steps through every combination of read-enable, write-enable and way-valid, so that abnormal control states such as a read and a write in the same cycle are applied.

Each vector leaves through a valid/ready stream. A vector is consumed on a clock edge where `vec_valid` and `vec_ready` are both high. While `vec_valid` is high and `vec_ready` is low, every vector field holds its value and the sequence does not advance. The consumer may keep `vec_ready` low for any number of cycles. `start` and `done` are plain control pins.

The LFSR field slices assume `SET_W + WAY_W + 1 <= 16` and `TAG_W <= 16`.

Top module: `tag_stim_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `vec_valid` and `done` are 0 and `vec_phase` is 0 (idle).
- R2: A `start` seen while idle makes `vec_valid` 1 on the next cycle with `vec_phase`=1 and `vec_idx`=0. A `start` while a run is under way has no effect on the vector stream.
- R3: While `vec_valid`=1 and `vec_ready`=0, every vector output holds its value and `vec_valid` stays 1.
- R4: Phase 1 (seeding) issues `INIT_CNT` stores. Vector k goes to set k, way k mod 8, with data 0.
- R5: Phase 2 stores to sets 0 up to NSETS-1 in order, way 0, with data equal to the set number. Phase 3 then loads from sets NSETS-1 down to 0, way 0, with data 0.
- R6: Phase 4 issues 2*TAG_W stores to set 0, way 0. For k < TAG_W the data is 1<<k. After that the data is the inverse of 1<<(k-TAG_W).
- R7: Phase 5 issues RAND_CNT vectors from an LFSR s that is loaded at start with `seed`, or with 1 if `seed` is 0. The LFSR steps once per consumed vector as s = {s[14:0], s[15]^s[13]^s[12]^s[10]}. s[0]=1 selects a store and s[0]=0 a load. The set is s[SET_W:1], the way is the next WAY_W bits, and the data is the top TAG_W bits.
- R8: Phase 6 issues 8 vectors. `vec_ctl` = {read-enable, write-enable, way-valid} equals k for vector k. The op is store for write-only, load for read-only, and idle otherwise. Set, way and data are 0.
- R9: Op codes are 0 idle, 1 store, 2 load. In phases 1 to 5 `vec_ctl` is 3'b011 for a store and 3'b101 for a load. Phases run in the order 1 to 6, and `vec_idx` rises by one per consumed vector.
- R10: On the cycle after the last phase-6 vector is consumed, `done` is 1 for exactly one cycle and `vec_valid` is 0. The block then stays idle until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| seed | input | 16 | LFSR seed, latched at start |
| done | output | 1 | One-cycle pulse after the final vector |
| vec_valid | output | 1 | Vector fields are valid |
| vec_ready | input | 1 | Consumer accepts the vector |
| vec_op | output | 2 | 0 idle, 1 store, 2 load |
| vec_set | output | SET_W | Set address |
| vec_way | output | WAY_W | Way select |
| vec_data | output | TAG_W | Write data |
| vec_ctl | output | 3 | {read-enable, write-enable, way-valid} |
| vec_phase | output | 3 | Phase tag, 0 when idle |
| vec_idx | output | IDX_W | Global vector index within the run |

## Verification
Full runs are consumed with `vec_ready` held high, and with `vec_ready` dropped every third cycle. Holding ready high exposes ordering and index errors. The stalled run shows whether fields drift or the sequence skips while back-pressured. Two seeds are used, one nonzero and one zero. They separate correct LFSR tap and slice use from the zero-seed substitution. A `start` pulse placed mid-run shows whether a busy restart is wrongly taken. The single-cycle `done` and the idle state after it are checked at the end of each run.

// File: rtl/tag_stim_pkg.sv
package tag_stim_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SEED = 3'd1,
    PH_AWR  = 3'd2,
    PH_ARD  = 3'd3,
    PH_DMAR = 3'd4,
    PH_RAND = 3'd5,
    PH_ABN  = 3'd6
  } phase_e;

  localparam logic [1:0] OP_IDLE  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_LOAD  = 2'd2;

  localparam logic [2:0] CTL_ST = 3'b011;
  localparam logic [2:0] CTL_LD = 3'b101;
endpackage

// File: rtl/tag_stim_lfsr.sv
module tag_stim_lfsr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] seed,
  input  logic        step,
  output logic [15:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= 16'h0001;
    else if (load) state <= (seed == 16'h0000) ? 16'h0001 : seed;
    else if (step) state <= {state[14:0], fb};
  end

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 16'h0000);
endmodule

// File: rtl/tag_stim_seq.sv
module tag_stim_seq
  import tag_stim_pkg::*;
#(
  parameter int NSETS    = 16,
  parameter int TAG_W    = 8,
  parameter int INIT_CNT = 4,
  parameter int RAND_CNT = 16,
  parameter int CNT_W    = 5,
  parameter int IDX_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             accept,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  logic [CNT_W-1:0] last;

  always_comb begin
    case (phase)
      PH_SEED: last = CNT_W'(INIT_CNT - 1);
      PH_AWR:  last = CNT_W'(NSETS - 1);
      PH_ARD:  last = CNT_W'(NSETS - 1);
      PH_DMAR: last = CNT_W'(2 * TAG_W - 1);
      PH_RAND: last = CNT_W'(RAND_CNT - 1);
      default: last = CNT_W'(7);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase <= PH_SEED;
          cnt   <= '0;
          idx   <= '0;
        end
      end else if (accept) begin
        idx <= idx + 1'b1;
        if (cnt == last) begin
          cnt <= '0;
          if (phase == PH_ABN) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            phase <= phase_e'(phase + 3'd1);
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tag_stim_fmt.sv
module tag_stim_fmt
  import tag_stim_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int WAY_W = 3,
  parameter int TAG_W = 8,
  parameter int CNT_W = 5
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic [15:0]      rnd,
  output logic [1:0]       op,
  output logic [SET_W-1:0] set,
  output logic [WAY_W-1:0] way,
  output logic [TAG_W-1:0] data,
  output logic [2:0]       ctl
);
  localparam int NSETS = 1 << SET_W;
  logic [TAG_W-1:0] walk;
  logic [2:0]       combo;

  assign walk  = (int'(cnt) < TAG_W) ? (TAG_W'(1) << cnt)
                                     : ~(TAG_W'(1) << (int'(cnt) - TAG_W));
  assign combo = 3'(cnt);

  always_comb begin
    op   = OP_IDLE;
    set  = '0;
    way  = '0;
    data = '0;
    ctl  = 3'b000;
    case (phase)
      PH_SEED: begin
        op = OP_STORE; ctl = CTL_ST;
        set = SET_W'(cnt); way = WAY_W'(cnt);
      end
      PH_AWR: begin
        op = OP_STORE; ctl = CTL_ST;
        set = SET_W'(cnt); data = TAG_W'(cnt);
      end
      PH_ARD: begin
        op = OP_LOAD; ctl = CTL_LD;
        set = SET_W'(NSETS - 1 - int'(cnt));
      end
      PH_DMAR: begin
        op = OP_STORE; ctl = CTL_ST; data = walk;
      end
      PH_RAND: begin
        op   = rnd[0] ? OP_STORE : OP_LOAD;
        ctl  = rnd[0] ? CTL_ST : CTL_LD;
        set  = rnd[SET_W:1];
        way  = rnd[SET_W+WAY_W:SET_W+1];
        data = rnd[15 -: TAG_W];
      end
      PH_ABN: begin
        ctl = combo;
        if (combo[1] && !combo[2])      op = OP_STORE;
        else if (combo[2] && !combo[1]) op = OP_LOAD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tag_stim_gen.sv
module tag_stim_gen
  import tag_stim_pkg::*;
#(
  parameter int SET_W    = 4,
  parameter int WAYS     = 8,
  parameter int TAG_W    = 8,
  parameter int INIT_CNT = 4,
  parameter int RAND_CNT = 16,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int NSETS   = 1 << SET_W,
  localparam int TOTAL   = INIT_CNT + 2 * NSETS + 2 * TAG_W + RAND_CNT + 8,
  localparam int IDX_W   = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      seed,
  output logic             done,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [1:0]       vec_op,
  output logic [SET_W-1:0] vec_set,
  output logic [WAY_W-1:0] vec_way,
  output logic [TAG_W-1:0] vec_data,
  output logic [2:0]       vec_ctl,
  output logic [2:0]       vec_phase,
  output logic [IDX_W-1:0] vec_idx
);
  localparam int M1     = (NSETS > 2 * TAG_W) ? NSETS : 2 * TAG_W;
  localparam int M2     = (M1 > RAND_CNT) ? M1 : RAND_CNT;
  localparam int M3     = (M2 > INIT_CNT) ? M2 : INIT_CNT;
  localparam int MAXLEN = (M3 > 8) ? M3 : 8;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      rnd;
  logic             accept, launch;

  assign vec_valid = (phase != PH_IDLE);
  assign accept    = vec_valid && vec_ready;
  assign launch    = start && !vec_valid;
  assign vec_phase = phase;

  tag_stim_seq #(
    .NSETS(NSETS), .TAG_W(TAG_W), .INIT_CNT(INIT_CNT),
    .RAND_CNT(RAND_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .phase(phase), .cnt(cnt), .idx(vec_idx), .done(done)
  );

  tag_stim_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(launch), .seed(seed),
    .step(accept && phase == PH_RAND), .state(rnd)
  );

  tag_stim_fmt #(
    .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_fmt (
    .phase(phase), .cnt(cnt), .rnd(rnd), .op(vec_op), .set(vec_set),
    .way(vec_way), .data(vec_data), .ctl(vec_ctl)
  );

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_op) &&
      $stable(vec_set) && $stable(vec_way) && $stable(vec_data) &&
      $stable(vec_ctl) && $stable(vec_phase) && $stable(vec_idx)));

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && vec_valid) |-> (vec_idx == $past(vec_idx) + 1'b1));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vec_valid);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (vec_valid && vec_phase == 3'd1 && vec_idx == '0));
endmodule

// File: tb/tag_stim_gen_tb.sv
module tag_stim_gen_tb;
  localparam int CLK_P = 10;
  localparam int NPH = 6;
  localparam int PH_LEN [NPH] = '{4, 16, 16, 16, 16, 8};
  // run table: seed, stall mode, effective seed expected (R7), busy-start poke index
  localparam logic [15:0] RUN_SEED [2] = '{16'hACE1, 16'h0000};
  localparam logic        RUN_STALL[2] = '{1'b0, 1'b1};
  localparam logic [15:0] RUN_EFF  [2] = '{16'hACE1, 16'h0001};
  localparam int          RUN_POKE [2] = '{-1, 10};

  logic clk = 0, rst_n = 0, start = 0, vec_ready = 0;
  logic [15:0] seed = 0;
  logic done, vec_valid;
  logic [1:0] vec_op;
  logic [3:0] vec_set;
  logic [2:0] vec_way;
  logic [7:0] vec_data;
  logic [2:0] vec_ctl, vec_phase;
  logic [6:0] vec_idx;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  tag_stim_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .done(done),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_op(vec_op),
    .vec_set(vec_set), .vec_way(vec_way), .vec_data(vec_data),
    .vec_ctl(vec_ctl), .vec_phase(vec_phase), .vec_idx(vec_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] model(input int ph, input int k, input logic [15:0] s);
    logic [1:0] op; logic [3:0] st; logic [2:0] wy; logic [7:0] dt; logic [2:0] ct;
    op = 0; st = 0; wy = 0; dt = 0; ct = 0;
    case (ph)
      1: begin op = 1; st = 4'(k); wy = 3'(k); ct = 3'b011; end
      2: begin op = 1; st = 4'(k); dt = 8'(k); ct = 3'b011; end
      3: begin op = 2; st = 4'(15 - k); ct = 3'b101; end
      4: begin op = 1; ct = 3'b011; dt = (k < 8) ? (8'd1 << k) : ~(8'd1 << (k - 8)); end
      5: begin op = s[0] ? 2'd1 : 2'd2; ct = s[0] ? 3'b011 : 3'b101;
               st = s[4:1]; wy = s[7:5]; dt = s[15:8]; end
      default: begin ct = 3'(k);
               op = (ct[1] && !ct[2]) ? 2'd1 : (ct[2] && !ct[1]) ? 2'd2 : 2'd0; end
    endcase
    return {op, st, wy, dt, ct, 1'b0};
  endfunction

  task automatic do_run(input int r);
    logic [15:0] s;
    int g;
    logic [20:0] held;
    bit stalled;
    s = RUN_EFF[r];
    g = 0;
    seed = RUN_SEED[r];
    @(negedge clk); start = 1; vec_ready = 0;
    @(negedge clk); start = 0;
    chk(vec_valid && vec_phase == 1 && vec_idx == 0, "R2 launch", {vec_valid, vec_phase, vec_idx}, {1'b1, 3'd1, 7'd0});
    stalled = 0;
    held = '0;
    for (int p = 0; p < NPH; p++) begin
      for (int k = 0; k < PH_LEN[p]; k++) begin
        logic [20:0] exp, act;
        exp = model(p + 1, k, s);
        forever begin
          @(negedge clk);
          start = (g == RUN_POKE[r]);
          cyc++;
          act = {vec_op, vec_set, vec_way, vec_data, vec_ctl, 1'b0};
          if (stalled)
            chk(vec_valid && act == held, "R3 hold under stall", act, held);
          vec_ready = !RUN_STALL[r] || (cyc % 3 != 0);
          stalled = vec_valid && !vec_ready;
          held = act;
          if (vec_valid && vec_ready) break;
        end
        chk(act == exp, (p == 0) ? "R4 seed" : (p < 3) ? "R5 addr march" :
            (p == 3) ? "R6 data march" : (p == 4) ? "R7 random" : "R8 abnormal", act, exp);
        chk(vec_phase == 3'(p + 1) && vec_idx == 7'(g), "R9 order/index, R2 busy start",
            {vec_phase, vec_idx}, {3'(p + 1), 7'(g)});
        if (p == 4) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        g++;
      end
    end
    @(negedge clk); start = 0; vec_ready = 0;
    chk(done && !vec_valid, "R10 done pulse", {done, vec_valid}, 2'b10);
    @(negedge clk);
    chk(!done && !vec_valid && vec_phase == 0, "R10 idle after", {done, vec_valid, vec_phase}, 5'd0);
    repeat (3) @(negedge clk);
    chk(!vec_valid, "R10 stays idle", vec_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!vec_valid && !done && vec_phase == 0, "R1 in reset", {vec_valid, done, vec_phase}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!vec_valid && !done && vec_phase == 0, "R1 after reset", {vec_valid, done, vec_phase}, 0);
    vec_ready = 1;
    repeat (2) @(negedge clk);
    chk(!vec_valid, "R2 no start no run", vec_valid, 0);
    for (int r = 0; r < 2; r++) do_run(r);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule